// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It draws on two sources. The first is a per-branch path: a history table indexed by PC bits records the recent outcomes of each branch, and that history selects a saturating counter. The second is a global path: a shared register holds the outcomes of the most recent branches in the order they occurred, and that register selects a second saturating counter. A third table, also indexed by the global history, learns for each history pattern which of the two paths has been more reliable, and picks between them.

A fetch stage presents a PC and gets back a direction along with a metadata word in the same cycle. The global history advances speculatively with the predicted direction. Once the branch resolves, the metadata and the real outcome are returned on the train port, which updates the counters, the chooser and the per-branch history. On a mispredict, the repair port rebuilds the global history from the snapshot held in the metadata, with the true outcome appended.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every per-branch history entry and the global history are zero. Every per-branch counter holds 3 (weakly not-taken on a 3-bit scale), every global counter holds 1, and every chooser counter holds 1 (weakly favouring the global path). As a result, every prediction made right after reset is not-taken.
- R2: The per-branch history table is indexed by PC bits [LIDX_W+1:2]. The other PC bits have no effect.
- R3: For any mix of predictions, training and repairs, `pred_taken` equals the per-branch counter MSB when the chooser MSB is 1, and the global counter MSB when the chooser MSB is 0.
- R4: The per-branch counter is selected by the branch's per-branch history. The global counter and the chooser counter are both selected by the current global history register.
- R5: Training moves both the selected per-branch counter and the selected global counter up by one on taken and down by one on not-taken. A counter at its maximum stays there when moved up, and a counter at zero stays there when moved down.
- R6: When exactly one component prediction recorded in the metadata matches the outcome, the chooser counter at the snapshot index moves one step toward that component (up for local, down for global), saturating at 0 and 3. When both components were right, or both were wrong, the chooser counter is left unchanged.
- R7: In a cycle with a prediction request and no repair, the global history shifts left by one and the predicted direction enters bit 0. With neither request nor repair, the global history holds its value.
- R8: A repair sets the global history to {snapshot[GH_W-2:0], actual outcome}. A repair takes precedence over a prediction shift in the same cycle.
- R9: Training shifts the actual outcome into bit 0 of the stored per-branch history entry named by the metadata PC index.
- R10: When a prediction and a training update fall in the same cycle and touch the same entries, the prediction sees the values as they stood before the update.
- R11: With default parameters the metadata is laid out as follows: [33:24] PC index, [23:14] per-branch history used, [13:2] global history snapshot, [1] per-branch component prediction, [0] global component prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request; advances global history |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_taken | output | 1 | Predicted direction |
| pred_meta | output | LIDX_W+LH_W+GH_W+2 | Metadata to return at training or repair |
| train_valid | input | 1 | Training request |
| train_meta | input | LIDX_W+LH_W+GH_W+2 | Metadata from the matching prediction |
| train_taken | input | 1 | Resolved outcome for training |
| repair_valid | input | 1 | Global history repair request |
| repair_meta | input | LIDX_W+LH_W+GH_W+2 | Metadata of the mispredicted branch |
| repair_taken | input | 1 | Resolved outcome of the mispredicted branch |

## Verification
The assertions take for granted that the metadata on the repair port is a word that the predict port actually produced. Under that assumption, the global history after a repair is fully determined by the metadata's snapshot field. The assertions also assume that the predict-side output is only meaningful when `pred_valid` is high. The stimulus honours both: every repair and every training call reuses a metadata word that the bench's own model produced for an earlier prediction, and the only exception is directed cases that build a word with a chosen snapshot to place the global history at a known value. Randomised traffic mixes predictions, delayed training and occasional repairs over a small set of PCs, so that history entries collide and counters reach both limits.

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W   = 32,
  parameter int LIDX_W = 10,
  parameter int LH_W   = 10,
  parameter int LCTR_W = 3,
  parameter int GH_W   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pred_valid,
  input  logic [PC_W-1:0]               pred_pc,
  output logic                          pred_taken,
  output logic [LIDX_W+LH_W+GH_W+1:0]   pred_meta,
  input  logic                          train_valid,
  input  logic [LIDX_W+LH_W+GH_W+1:0]   train_meta,
  input  logic                          train_taken,
  input  logic                          repair_valid,
  input  logic [LIDX_W+LH_W+GH_W+1:0]   repair_meta,
  input  logic                          repair_taken
);
  localparam int META_W = LIDX_W + LH_W + GH_W + 2;
  localparam int LSIZE  = 1 << LIDX_W;
  localparam int LCSIZE = 1 << LH_W;
  localparam int GSIZE  = 1 << GH_W;
  localparam logic [LCTR_W-1:0] LCTR_MAX  = '1;
  localparam logic [LCTR_W-1:0] LCTR_INIT = LCTR_MAX >> 1;

  logic [LH_W-1:0]   lhist_tab [LSIZE];
  logic [LCTR_W-1:0] lctr      [LCSIZE];
  logic [1:0]        gctr      [GSIZE];
  logic [1:0]        choice    [GSIZE];
  logic [GH_W-1:0]   ghr;

  logic [LIDX_W-1:0] p_idx;
  logic [LH_W-1:0]   p_lh;
  logic              p_lp, p_gp, p_sel_local;

  assign p_idx       = pred_pc[2 +: LIDX_W];
  assign p_lh        = lhist_tab[p_idx];
  assign p_lp        = lctr[p_lh][LCTR_W-1];
  assign p_gp        = gctr[ghr][1];
  assign p_sel_local = choice[ghr][1];
  assign pred_taken  = p_sel_local ? p_lp : p_gp;
  assign pred_meta   = {p_idx, p_lh, ghr, p_lp, p_gp};

  logic [LIDX_W-1:0] t_idx;
  logic [LH_W-1:0]   t_lh;
  logic [GH_W-1:0]   t_gh;
  logic              t_lp, t_gp;
  logic [GH_W-1:0]   r_gh;

  assign t_idx = train_meta[META_W-1 -: LIDX_W];
  assign t_lh  = train_meta[GH_W+2 +: LH_W];
  assign t_gh  = train_meta[2 +: GH_W];
  assign t_lp  = train_meta[1];
  assign t_gp  = train_meta[0];
  assign r_gh  = repair_meta[2 +: GH_W];

  logic unused_bits;
  assign unused_bits = ^{pred_pc[PC_W-1:LIDX_W+2], pred_pc[1:0],
                         repair_meta[META_W-1:GH_W+1], repair_meta[1:0]};

  logic [LCTR_W-1:0] lc_cur, lc_nxt;
  logic [1:0]        gc_cur, gc_nxt, ch_cur, ch_nxt;

  assign lc_cur = lctr[t_lh];
  assign gc_cur = gctr[t_gh];
  assign ch_cur = choice[t_gh];

  always_comb begin
    lc_nxt = lc_cur;
    if (train_taken && lc_cur != LCTR_MAX) lc_nxt = lc_cur + 1'b1;
    else if (!train_taken && lc_cur != '0) lc_nxt = lc_cur - 1'b1;
    gc_nxt = gc_cur;
    if (train_taken && gc_cur != 2'd3) gc_nxt = gc_cur + 2'd1;
    else if (!train_taken && gc_cur != 2'd0) gc_nxt = gc_cur - 2'd1;
    ch_nxt = ch_cur;
    if (t_lp != t_gp) begin
      if (t_lp == train_taken && ch_cur != 2'd3) ch_nxt = ch_cur + 2'd1;
      else if (t_gp == train_taken && ch_cur != 2'd0) ch_nxt = ch_cur - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LSIZE; i++) lhist_tab[i] <= '0;
      for (int i = 0; i < LCSIZE; i++) lctr[i] <= LCTR_INIT;
      for (int i = 0; i < GSIZE; i++) begin
        gctr[i]   <= 2'd1;
        choice[i] <= 2'd1;
      end
    end else if (train_valid) begin
      lhist_tab[t_idx] <= {lhist_tab[t_idx][LH_W-2:0], train_taken};
      lctr[t_lh]       <= lc_nxt;
      gctr[t_gh]       <= gc_nxt;
      choice[t_gh]     <= ch_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            ghr <= '0;
    else if (repair_valid) ghr <= {r_gh[GH_W-2:0], repair_taken};
    else if (pred_valid)   ghr <= {ghr[GH_W-2:0], pred_taken};
  end
endmodule

// File: rtl/tournament_predictor_sva.sv
module tournament_predictor_sva #(
  parameter int PC_W   = 32,
  parameter int LIDX_W = 10,
  parameter int LH_W   = 10,
  parameter int GH_W   = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        pred_valid,
  input logic [PC_W-1:0]             pred_pc,
  input logic                        pred_taken,
  input logic [LIDX_W+LH_W+GH_W+1:0] pred_meta,
  input logic                        repair_valid,
  input logic [LIDX_W+LH_W+GH_W+1:0] repair_meta,
  input logic                        repair_taken,
  input logic [GH_W-1:0]             ghr
);
  localparam int META_W = LIDX_W + LH_W + GH_W + 2;

  AST_GHR_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !repair_valid |=> ghr == {$past(ghr[GH_W-2:0]), $past(pred_taken)}); // R7

  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid && !repair_valid |=> $stable(ghr)); // R7

  AST_GHR_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    repair_valid |=> ghr == {$past(repair_meta[2 +: GH_W-1]), $past(repair_taken)}); // R8

  AST_META_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> pred_meta[2 +: GH_W] == ghr); // R11

  AST_META_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> pred_meta[META_W-1 -: LIDX_W] == pred_pc[2 +: LIDX_W]); // R2

  AST_AGREE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && (pred_meta[1] == pred_meta[0]) |-> pred_taken == pred_meta[0]); // R3
endmodule

bind tournament_predictor tournament_predictor_sva #(
  .PC_W(PC_W), .LIDX_W(LIDX_W), .LH_W(LH_W), .GH_W(GH_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
  .pred_taken(pred_taken), .pred_meta(pred_meta), .repair_valid(repair_valid),
  .repair_meta(repair_meta), .repair_taken(repair_taken), .ghr(ghr)
);

// File: tb/tournament_predictor_test.sv
`timescale 1ns/100ps
module tournament_predictor_test;
  localparam int PC_W = 32, LIDX_W = 10, LH_W = 10, GH_W = 12;
  localparam int MW = LIDX_W + LH_W + GH_W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pred_valid = 1'b0, train_valid = 1'b0, repair_valid = 1'b0;
  logic train_taken = 1'b0, repair_taken = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic [MW-1:0] train_meta = '0, repair_meta = '0;
  logic pred_taken;
  logic [MW-1:0] pred_meta;

  always #2.5 clk = ~clk;

  tournament_predictor uut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_meta(pred_meta), .train_valid(train_valid),
    .train_meta(train_meta), .train_taken(train_taken), .repair_valid(repair_valid),
    .repair_meta(repair_meta), .repair_taken(repair_taken)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [LH_W-1:0] m_lh [1<<LIDX_W];
  logic [2:0]      m_lc [1<<LH_W];
  logic [1:0]      m_gc [1<<GH_W];
  logic [1:0]      m_ch [1<<GH_W];
  logic [GH_W-1:0] m_ghr;

  bit            q_t [$];
  logic [MW-1:0] q_m [$];
  string         q_tag [$];

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < (1<<LIDX_W); i++) m_lh[i] = '0;
    for (int i = 0; i < (1<<LH_W); i++) m_lc[i] = 3'd3;
    for (int i = 0; i < (1<<GH_W); i++) begin m_gc[i] = 2'd1; m_ch[i] = 2'd1; end
    m_ghr = '0;
  endtask

  function automatic logic [MW-1:0] mk_meta(input logic [LIDX_W-1:0] idx, input logic [LH_W-1:0] lh,
                                            input logic [GH_W-1:0] gh, input bit lp, input bit gp);
    return {idx, lh, gh, lp, gp};
  endfunction

  task automatic cyc(input bit pv, input logic [PC_W-1:0] pc,
                     input bit tv, input logic [MW-1:0] tm, input bit tt,
                     input bit rv, input logic [MW-1:0] rm, input bit rt,
                     input string tag, output logic [MW-1:0] pm);
    logic [LIDX_W-1:0] idx, t_idx;
    logic [LH_W-1:0] lh, t_lh;
    logic [GH_W-1:0] t_gh;
    bit lp, gp, t;
    @(negedge clk);
    idx = pc[2 +: LIDX_W];
    lh  = m_lh[idx];
    lp  = m_lc[lh][2];
    gp  = m_gc[m_ghr][1];
    t   = m_ch[m_ghr][1] ? lp : gp;
    pm  = {idx, lh, m_ghr, lp, gp};
    pred_valid = pv; pred_pc = pc;
    train_valid = tv; train_meta = tm; train_taken = tt;
    repair_valid = rv; repair_meta = rm; repair_taken = rt;
    if (pv) begin q_t.push_back(t); q_m.push_back(pm); q_tag.push_back(tag); end
    if (tv) begin
      t_idx = tm[MW-1 -: LIDX_W]; t_lh = tm[GH_W+2 +: LH_W]; t_gh = tm[2 +: GH_W];
      m_lh[t_idx] = {m_lh[t_idx][LH_W-2:0], tt};
      if (tt && m_lc[t_lh] != 3'd7) m_lc[t_lh]++;
      else if (!tt && m_lc[t_lh] != 3'd0) m_lc[t_lh]--;
      if (tt && m_gc[t_gh] != 2'd3) m_gc[t_gh]++;
      else if (!tt && m_gc[t_gh] != 2'd0) m_gc[t_gh]--;
      if (tm[1] != tm[0]) begin
        if (tm[1] == tt && m_ch[t_gh] != 2'd3) m_ch[t_gh]++;
        else if (tm[0] == tt && m_ch[t_gh] != 2'd0) m_ch[t_gh]--;
      end
    end
    if (rv) m_ghr = {rm[2 +: GH_W-1], rt};
    else if (pv) m_ghr = {m_ghr[GH_W-2:0], t};
  endtask

  logic [MW-1:0] dummy;
  task automatic predict(input logic [PC_W-1:0] pc, input string tag);
    cyc(1, pc, 0, '0, 0, 0, '0, 0, tag, dummy);
  endtask
  task automatic train(input logic [MW-1:0] tm, input bit tt);
    cyc(0, '0, 1, tm, tt, 0, '0, 0, "", dummy);
  endtask
  task automatic set_ghr(input logic [GH_W-1:0] g);
    cyc(0, '0, 0, '0, 0, 1, mk_meta('0, '0, {1'b0, g[GH_W-1:1]}, 0, 0), g[0], "", dummy);
  endtask
  task automatic idle();
    cyc(0, '0, 0, '0, 0, 0, '0, 0, "", dummy);
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && pred_valid && !finished) begin
      if (q_t.size() == 0) chk("R3 unexpected prediction", 0, 0, 1);
      else begin
        bit et; logic [MW-1:0] em; string tg;
        et = q_t.pop_front(); em = q_m.pop_front(); tg = q_tag.pop_front();
        chk({tg, " direction"}, pred_taken == et, 64'(pred_taken), 64'(et));
        chk({tg, " R11 metadata"}, pred_meta == em, 64'(pred_meta), 64'(em));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      chk("watchdog", 0, 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [MW-1:0] hist [$];
  initial begin
    logic [MW-1:0] pm;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    predict(32'h0, "R1");
    predict(32'h40, "R1");
    predict(32'h0000_1FFC, "R2");
    predict(32'hFFFF_F004, "R2");

    // R4/R5: global counter at history 0 goes taken
    train(mk_meta('0, '0, '0, 0, 0), 1);
    set_ghr('0);
    predict(32'h40, "R4");
    predict(32'h80, "R7");
    predict(32'h84, "R7");

    // R5: saturation of global counter at 0x055
    repeat (5) train(mk_meta(10'd7, 10'h3F0, 12'h055, 0, 0), 1);
    train(mk_meta(10'd7, 10'h3F0, 12'h055, 0, 0), 0);
    set_ghr(12'h055); predict(32'h100, "R5");
    repeat (3) train(mk_meta(10'd7, 10'h3F0, 12'h055, 0, 0), 0);
    train(mk_meta(10'd7, 10'h3F0, 12'h055, 0, 0), 1);
    set_ghr(12'h055); predict(32'h100, "R5");

    // R6: chooser moves toward local; both-wrong leaves it alone
    set_ghr(12'h0AA); predict(32'h200, "R6");
    train(mk_meta(10'd9, 10'h3FF, 12'h0AA, 1, 1), 1);
    train(mk_meta(10'd9, 10'h3FF, 12'h0AA, 0, 1), 0);
    set_ghr(12'h0AA); predict(32'h200, "R6");
    train(mk_meta(10'd9, 10'h3FE, 12'h0AA, 0, 0), 1);
    set_ghr(12'h0AA); predict(32'h200, "R6");

    // R9: per-branch history shifts actual outcomes
    train(mk_meta(10'd16, '0, 12'h300, 0, 0), 1);
    train(mk_meta(10'd16, '0, 12'h300, 0, 0), 0);
    train(mk_meta(10'd16, '0, 12'h300, 0, 0), 1);
    predict(32'h40, "R9");

    // R8: repair overrides same-cycle prediction shift
    cyc(1, 32'h44, 0, '0, 0, 1, mk_meta('0, '0, 12'hA5A, 0, 0), 1, "R8", pm);
    predict(32'h44, "R8");

    // R10: same-cycle train and predict on one entry
    predict(32'h48, "R10");
    cyc(1, 32'h48, 1, mk_meta(10'd18, '0, m_ghr, 0, 0), 1, 0, '0, 0, "R10", pm);
    set_ghr(m_ghr);
    predict(32'h48, "R10");

    // R3: mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      bit dopred, dotrain, dorep, outc;
      logic [PC_W-1:0] pc;
      logic [MW-1:0] tm;
      dopred  = ($urandom % 4) != 0;
      dotrain = hist.size() > 3 && ($urandom % 3) != 0;
      dorep   = hist.size() > 3 && ($urandom % 11) == 0;
      outc    = $urandom % 2;
      pc      = {$urandom % 8, 2'b00} + 32'h1000;
      tm      = dotrain ? hist.pop_front() : '0;
      cyc(dopred, pc, dotrain, tm, outc, dorep, dorep ? hist[0] : '0, ~outc, "R3", pm);
      if (dopred) hist.push_back(pm);
      if (hist.size() > 16) void'(hist.pop_front());
    end

    idle(); idle(); idle();
    chk("R3 scoreboard drained", q_t.size() == 0, 64'(q_t.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule